// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Execute Unit

This unit is the execute stage for one family of 32-bit processor operations: multiply a signed 16-bit half of one source register by a signed 16-bit half of a second source register, add a full 32-bit signed addend, and return the low 32 bits for write-back. Each source contributes its lower or upper half under its own select bit, so there are four variants. If the exact sum does not fit in 32-bit signed range, a sticky saturation flag is raised. The multiply alone can never overflow.

The unit accepts the instruction word in either of two layouts. A format input chooses between the full-width layout and the mixed 16/32-bit layout. The unit decodes the register fields and half selects from the word, rejects words that do not belong to the family, and flags register-15 operands as unpredictable. The caller supplies a condition-passed bit and the three operand values, already read from the register file. All results are registered and appear one cycle after the input is presented. A synchronous clear input models a software write that resets the saturation flag.

Top module: `half_mac_unit`

## Requirements
- R1: The first multiplicand is `src_n[15:0]` when the first-source select bit is 0 and `src_n[31:16]` when it is 1. It is treated as signed, and the other half has no effect.
- R2: The second multiplicand is `src_m[15:0]` when the second-source select bit is 0 and `src_m[31:16]` when it is 1. It is treated as signed, and the other half has no effect.
- R3: For an accepted input with `in_valid` high at edge k, `out_valid` is high after edge k+1. In the same cycle `out_wdata` holds the low 32 bits of product plus signed `src_a`.
- R4: `q_flag` becomes 1 when a performed write's exact sum lies outside [-2^31, 2^31-1]. It then stays 1 through later operations, whether or not they overflow.
- R5: `q_clear` high at an edge drives `q_flag` to 0 after that edge. If an overflowing write is taken at the same edge, the flag is set instead.
- R6: Full-width layout (`narrow_fmt`=0) is accepted when [27:20]=0x10, bit 7=1, bit 4=0 and [31:28]≠0xF. Its fields are destination [19:16], addend [15:12], second source [11:8], second select bit 6, first select bit 5 and first source [3:0].
- R7: Mixed layout (`narrow_fmt`=1) is accepted when [31:20]=0xFB1 and [7:6]=00. Its fields are first source [19:16], addend [15:12], destination [11:8], first select bit 5, second select bit 4 and second source [3:0].
- R8: In the mixed layout an addend field of 0xF marks a non-accumulating form. It gives `out_undef`=1 and no write.
- R9: Register 15 in any of the four fields (full-width layout), or in the destination, first or second source (mixed layout), gives `out_unpred`=1. The write is suppressed and `q_flag` is unchanged.
- R10: With `cond_ok` low there is no write (`out_we`=0) and `q_flag` is unchanged.
- R11: A word matching neither layout, including a full-width word with [31:28]=0xF, gives `out_undef`=1, `out_unpred`=0 and no write.
- R12: Synchronous reset clears `q_flag`, `out_valid` and `out_we`.
- R13: A cycle with `in_valid` low gives `out_valid`=0 and `out_we`=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation presented this cycle |
| insn | input | 32 | Instruction word |
| narrow_fmt | input | 1 | 1 = mixed 16/32-bit layout, 0 = full-width layout |
| cond_ok | input | 1 | Condition check passed |
| src_n | input | 32 | First source register value |
| src_m | input | 32 | Second source register value |
| src_a | input | 32 | Addend register value |
| q_clear | input | 1 | Clear the saturation flag |
| out_valid | output | 1 | Result registered for last cycle's input |
| out_rd | output | 4 | Destination register index |
| out_wdata | output | 32 | Write-back data |
| out_we | output | 1 | Register write enable |
| out_unpred | output | 1 | Register 15 used in a checked field |
| out_undef | output | 1 | Word not accepted as this operation |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
Every result of this unit is due exactly one clock edge after its stimulus: write data, destination, enable, both error flags and the saturation flag. Clear requests and overflow sets also land on that same next edge. The bench drives each operation on the falling edge. It lets one rising edge pass and compares all outputs a quarter period later against a behavioural model, which updates its own copy of the flag at that same edge. Clear-and-set collisions, suppressed writes that would have overflowed, and idle cycles each get their own step, so any off-by-one in latency or in flag priority appears in the cycle where it would occur.

// File: rtl/half_mac_pkg.sv
package half_mac_pkg;

    localparam int INSN_W     = 32;
    localparam int REG_IDX_W  = 4;

    localparam logic [3:0]  COND_NEVER = 4'hF;
    localparam logic [7:0]  WIDE_OPC   = 8'h10;
    localparam logic [11:0] MIX_OPC    = 12'hFB1;
    localparam logic [REG_IDX_W-1:0] PC_IDX = '1;

    typedef struct packed {
        logic                 match;
        logic                 unpred;
        logic [REG_IDX_W-1:0] rd;
        logic                 top_n;
        logic                 top_m;
    } dec_t;

endpackage

// File: rtl/hm_decode.sv
module hm_decode
    import half_mac_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    input  logic              narrow_i,
    output dec_t              dec_o
);
    dec_t wide_d, mix_d;

    // Full-width layout
    always_comb begin
        logic [REG_IDX_W-1:0] rn, rm, ra;
        wide_d       = '0;
        rn           = insn_i[3:0];
        rm           = insn_i[11:8];
        ra           = insn_i[15:12];
        wide_d.rd    = insn_i[19:16];
        wide_d.top_m = insn_i[6];
        wide_d.top_n = insn_i[5];
        wide_d.match = (insn_i[31:28] != COND_NEVER) &&
                       (insn_i[27:20] == WIDE_OPC) &&
                       insn_i[7] && !insn_i[4];
        wide_d.unpred = (wide_d.rd == PC_IDX) || (rn == PC_IDX) ||
                        (rm == PC_IDX) || (ra == PC_IDX);
    end

    // Mixed 16/32-bit layout
    always_comb begin
        logic [REG_IDX_W-1:0] rn, rm, ra;
        mix_d       = '0;
        rn          = insn_i[19:16];
        ra          = insn_i[15:12];
        mix_d.rd    = insn_i[11:8];
        mix_d.top_n = insn_i[5];
        mix_d.top_m = insn_i[4];
        rm          = insn_i[3:0];
        mix_d.match = (insn_i[31:20] == MIX_OPC) &&
                      (insn_i[7:6] == 2'b00) &&
                      (ra != PC_IDX);
        mix_d.unpred = (mix_d.rd == PC_IDX) || (rn == PC_IDX) ||
                       (rm == PC_IDX);
    end

    always_comb begin
        dec_o        = narrow_i ? mix_d : wide_d;
        dec_o.unpred = dec_o.unpred && dec_o.match;
    end

endmodule

// File: rtl/hm_half_pick.sv
module hm_half_pick #(
    parameter int XLEN = 32,
    parameter int HALF = 16
) (
    input  logic [XLEN-1:0]        word_i,
    input  logic                   top_i,
    output logic signed [HALF-1:0] half_o
);
    always_comb begin
        half_o = top_i ? word_i[XLEN-1 -: HALF] : word_i[HALF-1:0];
    end
endmodule

// File: rtl/hm_mac_arith.sv
module hm_mac_arith #(
    parameter int XLEN = 32,
    parameter int HALF = 16
) (
    input  logic signed [HALF-1:0] mul_a_i,
    input  logic signed [HALF-1:0] mul_b_i,
    input  logic [XLEN-1:0]        acc_i,
    output logic [XLEN-1:0]        sum_o,
    output logic                   ovf_o
);
    localparam int PW = 2 * HALF;
    localparam int SW = XLEN + 1;

    logic signed [PW-1:0] prod;
    logic signed [SW-1:0] prod_x, acc_x, sum_x;

    always_comb begin
        prod   = PW'(mul_a_i) * PW'(mul_b_i);
        prod_x = {{(SW-PW){prod[PW-1]}}, prod};
        acc_x  = {acc_i[XLEN-1], acc_i};
        sum_x  = prod_x + acc_x;
    end

    assign sum_o = sum_x[XLEN-1:0];
    assign ovf_o = sum_x[SW-1] ^ sum_x[SW-2];
endmodule

// File: rtl/half_mac_unit.sv
module half_mac_unit
    import half_mac_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int HALF = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [INSN_W-1:0]    insn,
    input  logic                 narrow_fmt,
    input  logic                 cond_ok,
    input  logic [XLEN-1:0]      src_n,
    input  logic [XLEN-1:0]      src_m,
    input  logic [XLEN-1:0]      src_a,
    input  logic                 q_clear,
    output logic                 out_valid,
    output logic [REG_IDX_W-1:0] out_rd,
    output logic [XLEN-1:0]      out_wdata,
    output logic                 out_we,
    output logic                 out_unpred,
    output logic                 out_undef,
    output logic                 q_flag
);
    localparam int NSRC = 2;

    typedef struct packed {
        logic                 valid;
        logic                 we;
        logic                 unpred;
        logic                 undef;
        logic [REG_IDX_W-1:0] rd;
        logic [XLEN-1:0]      wdata;
        logic                 q;
    } state_t;

    state_t st_d, st_q;
    dec_t   dec;

    logic [XLEN-1:0]        src_word [NSRC];
    logic                   src_top  [NSRC];
    logic signed [HALF-1:0] src_half [NSRC];
    logic [XLEN-1:0]        sum;
    logic                   ovf;

    hm_decode u_dec (
        .insn_i   (insn),
        .narrow_i (narrow_fmt),
        .dec_o    (dec)
    );

    assign src_word[0] = src_n;
    assign src_word[1] = src_m;
    assign src_top[0]  = dec.top_n;
    assign src_top[1]  = dec.top_m;

    for (genvar g = 0; g < NSRC; g++) begin : g_pick
        hm_half_pick #(.XLEN(XLEN), .HALF(HALF)) u_pick (
            .word_i (src_word[g]),
            .top_i  (src_top[g]),
            .half_o (src_half[g])
        );
    end

    hm_mac_arith #(.XLEN(XLEN), .HALF(HALF)) u_arith (
        .mul_a_i (src_half[0]),
        .mul_b_i (src_half[1]),
        .acc_i   (src_a),
        .sum_o   (sum),
        .ovf_o   (ovf)
    );

    always_comb begin
        st_d        = st_q;
        st_d.valid  = in_valid;
        st_d.we     = 1'b0;
        st_d.unpred = 1'b0;
        st_d.undef  = 1'b0;
        if (in_valid) begin
            st_d.rd     = dec.rd;
            st_d.wdata  = sum;
            st_d.unpred = dec.unpred;
            st_d.undef  = !dec.match;
            st_d.we     = dec.match && !dec.unpred && cond_ok;
        end
        st_d.q = (st_q.q && !q_clear) || (st_d.we && ovf);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_rd     = st_q.rd;
    assign out_wdata  = st_q.wdata;
    assign out_we     = st_q.we;
    assign out_unpred = st_q.unpred;
    assign out_undef  = st_q.undef;
    assign q_flag     = st_q.q;

endmodule

// File: rtl/half_mac_unit_chk.sv
module half_mac_unit_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic cond_ok,
    input logic q_clear,
    input logic out_valid,
    input logic out_we,
    input logic out_unpred,
    input logic out_undef,
    input logic q_flag
);
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_we)); // R13
    AST_COND_GATES: assert property (@(posedge clk) disable iff (rst)
        out_we |-> $past(cond_ok)); // R10
    AST_UNPRED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        out_unpred |-> !out_we); // R9
    AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        out_undef |-> (!out_we && !out_unpred)); // R11
    AST_Q_STICKY: assert property (@(posedge clk) disable iff (rst)
        (q_flag && !q_clear) |=> q_flag); // R4
    AST_Q_RISE_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(q_flag) |-> out_we); // R4
    AST_Q_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (q_clear && !(in_valid && cond_ok)) |=> !q_flag); // R5
endmodule

bind half_mac_unit half_mac_unit_chk u_chk (.*);

// File: tb/half_mac_unit_test.sv
module half_mac_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, narrow_fmt, cond_ok, q_clear;
    logic [31:0] insn, src_n, src_m, src_a;
    logic        out_valid, out_we, out_unpred, out_undef, q_flag;
    logic [3:0]  out_rd;
    logic [31:0] out_wdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic exp_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    half_mac_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .narrow_fmt(narrow_fmt), .cond_ok(cond_ok), .src_n(src_n),
        .src_m(src_m), .src_a(src_a), .q_clear(q_clear),
        .out_valid(out_valid), .out_rd(out_rd), .out_wdata(out_wdata),
        .out_we(out_we), .out_unpred(out_unpred), .out_undef(out_undef),
        .q_flag(q_flag)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_wide(input logic [3:0] cond, rd, ra, rm,
                                             input logic m, n, input logic [3:0] rn);
        return {cond, 8'h10, rd, ra, rm, 1'b1, m, n, 1'b0, rn};
    endfunction

    function automatic logic [31:0] enc_mix(input logic [3:0] rn, ra, rd,
                                            input logic n, m, input logic [3:0] rm);
        return {12'hFB1, rn, ra, rd, 2'b00, n, m, rm};
    endfunction

    task automatic step(input string tag, input logic v, input logic fmt,
                        input logic [31:0] w, input logic cok,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] c, input logic clr);
        logic match, unp, nb, mb, ovf, e_we;
        logic [3:0] rd, ra, rm, rn;
        longint p, s;
        @(negedge clk);
        in_valid = v; narrow_fmt = fmt; insn = w; cond_ok = cok;
        src_n = a; src_m = b; src_a = c; q_clear = clr;
        if (!fmt) begin
            rd = w[19:16]; ra = w[15:12]; rm = w[11:8]; rn = w[3:0];
            mb = w[6]; nb = w[5];
            match = (w[31:28] != 4'hF) && (w[27:20] == 8'h10) && w[7] && !w[4];
            unp = (rd == 15) || (ra == 15) || (rm == 15) || (rn == 15);
        end else begin
            rn = w[19:16]; ra = w[15:12]; rd = w[11:8]; rm = w[3:0];
            nb = w[5]; mb = w[4];
            match = (w[31:20] == 12'hFB1) && (w[7:6] == 2'b00) && (ra != 15);
            unp = (rd == 15) || (rn == 15) || (rm == 15);
        end
        p = longint'($signed(nb ? a[31:16] : a[15:0])) *
            longint'($signed(mb ? b[31:16] : b[15:0]));
        s = p + longint'($signed(c));
        ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        e_we = v && match && !unp && cok;
        exp_q = (exp_q && !clr) || (e_we && ovf);
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk(tag, "out_valid", 32'(out_valid), 32'(v));
        chk(tag, "out_we", 32'(out_we), 32'(e_we));
        chk(tag, "out_undef", 32'(out_undef), 32'(v && !match));
        chk(tag, "out_unpred", 32'(out_unpred), 32'(v && match && unp));
        chk(tag, "q_flag", 32'(q_flag), 32'(exp_q));
        if (e_we) begin
            chk(tag, "out_rd", 32'(out_rd), 32'(rd));
            chk(tag, "out_wdata", out_wdata, s[31:0]);
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run hung actual=running expected=finished");
        summary();
    end

    initial begin
        rst = 1'b1; in_valid = 0; narrow_fmt = 0; insn = 0; cond_ok = 0;
        src_n = 0; src_m = 0; src_a = 0; q_clear = 0; exp_q = 0;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        chk("R12", "out_valid", 32'(out_valid), 0);
        chk("R12", "out_we", 32'(out_we), 0);
        chk("R12", "q_flag", 32'(q_flag), 0);
        @(negedge clk); rst = 1'b0;

        // R1 R2 R6: four half selections, full-width layout
        step("R1_R6_BB", 1, 0, enc_wide(4'hE, 4'd1, 4'd2, 4'd3, 0, 0, 4'd4), 1,
             32'h7777_0005, 32'h8888_FFFD, 32'd100, 0);
        step("R2_R6_BT", 1, 0, enc_wide(4'h0, 4'd5, 4'd2, 4'd3, 1, 0, 4'd4), 1,
             32'h7777_0005, 32'hFFF0_1234, 32'd7, 0);
        step("R1_R6_TB", 1, 0, enc_wide(4'h1, 4'd6, 4'd2, 4'd3, 0, 1, 4'd4), 1,
             32'h8000_1111, 32'h2222_0003, 32'hFFFF_FFFF, 0);
        step("R3_R6_TT", 1, 0, enc_wide(4'hE, 4'd14, 4'd2, 4'd3, 1, 1, 4'd4), 1,
             32'hFFFE_AAAA, 32'hFFFD_BBBB, 32'h1000_0000, 0);
        // R7: mixed layout
        step("R7_BB", 1, 1, enc_mix(4'd1, 4'd2, 4'd9, 0, 0, 4'd3), 1,
             32'h1234_7FFF, 32'h4321_7FFF, 32'd1, 0);
        step("R7_TB", 1, 1, enc_mix(4'd1, 4'd2, 4'd10, 1, 0, 4'd3), 1,
             32'h8000_0001, 32'h0000_7FFF, 32'd0, 0);
        step("R7_BT", 1, 1, enc_mix(4'd1, 4'd2, 4'd11, 0, 1, 4'd3), 1,
             32'h0000_FFFF, 32'h0002_0000, 32'd5, 0);
        step("R7_TT", 1, 1, enc_mix(4'd1, 4'd2, 4'd12, 1, 1, 4'd3), 1,
             32'h8000_0000, 32'h8000_0000, 32'd0, 0);
        // R13: idle
        step("R13", 0, 0, enc_wide(4'hE, 4'd1, 4'd2, 4'd3, 0, 0, 4'd4), 1,
             32'd1, 32'd1, 32'd1, 0);
        // R10: overflow operand but condition fails
        step("R10", 1, 0, enc_wide(4'hE, 4'd1, 4'd2, 4'd3, 0, 0, 4'd4), 0,
             32'd1, 32'd1, 32'h7FFF_FFFF, 0);
        // R4: positive overflow, then sticky through normal ops
        step("R4_pos", 1, 0, enc_wide(4'hE, 4'd1, 4'd2, 4'd3, 0, 0, 4'd4), 1,
             32'd1, 32'd1, 32'h7FFF_FFFF, 0);
        step("R4_sticky", 1, 0, enc_wide(4'hE, 4'd1, 4'd2, 4'd3, 0, 0, 4'd4), 1,
             32'd2, 32'd3, 32'd4, 0);
        // R5: clear alone
        step("R5_clear", 0, 0, 32'd0, 0, 32'd0, 32'd0, 32'd0, 1);
        // R4: negative overflow
        step("R4_neg", 1, 1, enc_mix(4'd1, 4'd2, 4'd3, 0, 0, 4'd4), 1,
             32'h0000_FFFF, 32'h0000_0001, 32'h8000_0000, 0);
        step("R5_clear2", 1, 0, enc_wide(4'hE, 4'd1, 4'd2, 4'd3, 0, 0, 4'd4), 1,
             32'd2, 32'd2, 32'd2, 1);
        // R5: clear and overflow at the same edge: set wins
        step("R5_collide", 1, 0, enc_wide(4'hE, 4'd1, 4'd2, 4'd3, 1, 1, 4'd4), 1,
             32'h8000_0000, 32'h8000_0000, 32'h4000_0000, 1);
        step("R5_clear3", 0, 0, 32'd0, 0, 32'd0, 32'd0, 32'd0, 1);
        // R9: register 15 cases, overflowing operands must not set flag
        step("R9_wide_rd", 1, 0, enc_wide(4'hE, 4'd15, 4'd2, 4'd3, 0, 0, 4'd4), 1,
             32'd1, 32'd1, 32'h7FFF_FFFF, 0);
        step("R9_wide_ra", 1, 0, enc_wide(4'hE, 4'd1, 4'd15, 4'd3, 0, 0, 4'd4), 1,
             32'd1, 32'd1, 32'h7FFF_FFFF, 0);
        step("R9_mix_rn", 1, 1, enc_mix(4'd15, 4'd2, 4'd3, 0, 0, 4'd4), 1,
             32'd1, 32'd1, 32'h7FFF_FFFF, 0);
        step("R9_mix_rm", 1, 1, enc_mix(4'd1, 4'd2, 4'd3, 0, 0, 4'd15), 1,
             32'd1, 32'd1, 32'h7FFF_FFFF, 0);
        // R8: mixed addend field 0xF
        step("R8", 1, 1, enc_mix(4'd1, 4'd15, 4'd3, 0, 0, 4'd4), 1,
             32'd1, 32'd1, 32'h7FFF_FFFF, 0);
        // R11: non-matching words
        step("R11_cond", 1, 0, enc_wide(4'hF, 4'd1, 4'd2, 4'd3, 0, 0, 4'd4), 1,
             32'd1, 32'd1, 32'd1, 0);
        step("R11_bit4", 1, 0, enc_wide(4'hE, 4'd1, 4'd2, 4'd3, 0, 0, 4'd4) | 32'h10, 1,
             32'd1, 32'd1, 32'd1, 0);
        step("R11_mix", 1, 1, enc_mix(4'd1, 4'd2, 4'd3, 0, 0, 4'd4) | 32'h80, 1,
             32'd1, 32'd1, 32'd1, 0);
        step("R11_fmt", 1, 1, enc_wide(4'hE, 4'd1, 4'd2, 4'd3, 0, 0, 4'd4), 1,
             32'd1, 32'd1, 32'd1, 0);
        // R3: mixed random traffic in both layouts
        for (int i = 0; i < 400; i++) begin
            logic f;
            logic [31:0] w;
            f = 1'($urandom);
            if (f)
                w = enc_mix(4'($urandom), 4'($urandom), 4'($urandom),
                            1'($urandom), 1'($urandom), 4'($urandom));
            else
                w = enc_wide(4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
                             1'($urandom), 1'($urandom), 4'($urandom));
            step("R3_rand", ($urandom % 8) != 0, f, w, ($urandom % 4) != 0,
                 $urandom, $urandom, $urandom, ($urandom % 16) == 0);
        end
        summary();
    end
endmodule